// File: doc/BRIEF.md
# SD Data-Phase Inactivity Timeout

This block guards the data phase of an SD host against a stalled card. Software programs a 4-bit exponent inside a 32-bit system-control word. When a data phase opens, or a data token or new block arrives, the host pulses `win_start`. The block then counts card clock ticks, qualified by `sd_ce`. If the count reaches 2^(code + BASE_SHIFT) before the next restart, it raises a sticky data-timeout flag and returns to idle.

With the default shift of 13, code n gives a window of 2^(n+13) card clocks. The window measures the gap since the last sign of progress, not the length of the whole transfer. A data-done indication stops the count. A data-reset request aborts the count and runs a short self-ending reset sequence, and software can watch that sequence finish on `dreset_busy`. The timeout flag is cleared by writing a one to its bit of the status word, so a write of all ones also clears it.

Top module: `sd_dto_timer`

## Requirements
- R1: After reset `dto_idle`=1, `dto_flag`=0 and `dreset_busy`=0, and the stored exponent is code 14. A window opened before any control write therefore lasts 2^(14+BASE_SHIFT) ticks.
- R2: A control write (`ctl_we`=1) stores `ctl_wdata[19:16]` as the exponent code n. A `win_start` pulse seen in idle opens a window. `dto_flag` rises and `dto_idle` returns to 1 on the clock edge that carries the 2^(n+BASE_SHIFT)-th `sd_ce` tick after the opening edge.
- R3: Code 15 behaves exactly like code 14.
- R4: The exponent is captured when a window opens. A control write during a running window changes only the windows opened after it.
- R5: A `win_start` pulse during a running window restarts the count from zero with a freshly captured exponent. No timeout occurs at the end of the old window.
- R6: Clock edges with `sd_ce`=0 do not advance the count.
- R7: `data_done` during a running window returns the block to idle on the next edge without setting the flag. This holds even when the final tick falls on that same edge.
- R8: `dto_flag` stays set until a write with `w1c_we`=1 and `w1c_data[4]`=1, which clears it on the next edge. A write with bit 4 clear leaves it set.
- R9: When expiry and a clear of the flag land on the same edge, the flag ends up set.
- R10: A `dreset_req` pulse aborts any window. For the next RST_CYC edges the block shows `dreset_busy`=1 and `dto_idle`=0, and then it returns to idle with `dreset_busy`=0. An aborted window never sets the flag, `win_start` is ignored while busy, and a flag already set is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_ce | input | 1 | Card clock tick qualifier |
| ctl_we | input | 1 | System-control word write strobe |
| ctl_wdata | input | WORD_W | System-control word; exponent in bits 19:16 |
| win_start | input | 1 | Open or restart the inactivity window |
| data_done | input | 1 | Data phase finished |
| dreset_req | input | 1 | Data-path reset request |
| w1c_we | input | 1 | Status write strobe |
| w1c_data | input | WORD_W | Status write data, ones clear |
| dto_flag | output | 1 | Sticky data-timeout status |
| dto_idle | output | 1 | No window running and no reset in progress |
| dreset_busy | output | 1 | Data reset sequence in progress |

## Verification
The bench goes after the exact expiry edge for several codes. A design that is off by one tick, or that ignores the clamp, would flag one edge early or late, or run twice as long for code 15. It restarts a window part-way through, drops `sd_ce` for a stretch, and rewrites the exponent mid-window. A design that reloads wrongly, counts untimed edges or reads the exponent live would expire at the wrong moment. It also lines up `data_done` and status clears exactly with the final tick, where wrong priority would leave a spurious flag or lose a real one. Finally it aborts a window with a data reset, where a design that kept counting would flag after the reset had finished.

// File: rtl/dto_pkg.sv
package dto_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RST  = 2'd2
  } dto_state_e;

  // Limit an exponent code to the largest legal value.
  function automatic logic [3:0] clamp_code(input logic [3:0] code,
                                            input logic [3:0] max_code);
    return (code > max_code) ? max_code : code;
  endfunction

endpackage

// File: rtl/dto_expreg.sv
module dto_expreg
  import dto_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CODE_W     = 4,
  parameter int FIELD_LSB  = 16,
  parameter int MAX_CODE   = 14,
  parameter int RESET_CODE = 14,
  parameter int BASE_SHIFT = 13,
  parameter int CNT_W      = BASE_SHIFT + MAX_CODE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  output logic [CNT_W-1:0]  lim_new
);

  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] RST_C = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] code_c;
  logic [31:0]       exp_sum;

  always_comb begin
    code_d = code_q;
    if (ctl_we) begin
      code_d = ctl_wdata[FIELD_LSB +: CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RST_C;
    end else begin
      code_q <= code_d;
    end
  end

  assign code_c  = clamp_code(code_q, MAX_C);
  assign exp_sum = 32'(code_c) + 32'(BASE_SHIFT);

  // One-hot limit: bit k set when the clamped exponent plus shift equals k.
  for (genvar g = 0; g < CNT_W; g++) begin : g_lim
    assign lim_new[g] = (exp_sum == 32'(g));
  end

endmodule

// File: rtl/dto_count.sv
module dto_count #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] lim_new,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] lim_q,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (load) begin
      cnt_d = '0;
      lim_d = lim_new;
    end else if (clr) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // The tick that would bring the count up to the limit ends the window.
  assign hit = cnt_en && (cnt_inc == lim_q);

endmodule

// File: rtl/dto_ctrl.sv
module dto_ctrl
  import dto_pkg::*;
#(
  parameter int RST_CYC = 2,
  parameter int RC_W    = (RST_CYC > 1) ? $clog2(RST_CYC) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sd_ce,
  input  logic       win_start,
  input  logic       data_done,
  input  logic       dreset_req,
  input  logic       hit,
  input  logic       clr_bit,
  output logic       load,
  output logic       clr,
  output logic       cnt_en,
  output dto_state_e st_q,
  output logic       flag_q
);

  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYC - 1);

  dto_state_e      st_d;
  logic [RC_W-1:0] rc_q;
  logic [RC_W-1:0] rc_d;
  logic            expire;
  logic            flag_d;

  assign cnt_en = (st_q == ST_RUN) && sd_ce;

  // Priority: data reset, then done, then restart, then expiry.
  always_comb begin
    st_d   = st_q;
    rc_d   = rc_q;
    load   = 1'b0;
    clr    = 1'b0;
    expire = 1'b0;
    if (dreset_req) begin
      st_d = ST_RST;
      rc_d = '0;
      clr  = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (win_start && !data_done) begin
            load = 1'b1;
            st_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (data_done) begin
            clr  = 1'b1;
            st_d = ST_IDLE;
          end else if (win_start) begin
            load = 1'b1;
          end else if (hit) begin
            expire = 1'b1;
            clr    = 1'b1;
            st_d   = ST_IDLE;
          end
        end
        ST_RST: begin
          clr = 1'b1;
          if (rc_q == RC_LAST) begin
            st_d = ST_IDLE;
          end else begin
            rc_d = rc_q + RC_W'(1);
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  // Set beats clear so a fresh expiry is never lost.
  always_comb begin
    flag_d = flag_q;
    if (expire) begin
      flag_d = 1'b1;
    end else if (clr_bit) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rc_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rc_q   <= rc_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/sd_dto_timer.sv
module sd_dto_timer
  import dto_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int CODE_W     = 4,
  parameter int FIELD_LSB  = 16,
  parameter int MAX_CODE   = 14,
  parameter int RESET_CODE = 14,
  parameter int BASE_SHIFT = 13,
  parameter int CNT_W      = BASE_SHIFT + MAX_CODE + 1,
  parameter int TO_BIT     = 4,
  parameter int RST_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_ce,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_wdata,
  input  logic              win_start,
  input  logic              data_done,
  input  logic              dreset_req,
  input  logic              w1c_we,
  input  logic [WORD_W-1:0] w1c_data,
  output logic              dto_flag,
  output logic              dto_idle,
  output logic              dreset_busy
);

  logic [CNT_W-1:0] lim_new;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             hit;
  logic             load;
  logic             clr;
  logic             cnt_en;
  logic             clr_bit;
  logic             run_s;
  dto_state_e       st_q;
  logic             unused_wbits;

  assign clr_bit      = w1c_we && w1c_data[TO_BIT];
  assign unused_wbits = ^{ctl_wdata, w1c_data};

  dto_expreg #(
    .WORD_W    (WORD_W),
    .CODE_W    (CODE_W),
    .FIELD_LSB (FIELD_LSB),
    .MAX_CODE  (MAX_CODE),
    .RESET_CODE(RESET_CODE),
    .BASE_SHIFT(BASE_SHIFT),
    .CNT_W     (CNT_W)
  ) u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .lim_new  (lim_new)
  );

  dto_count #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .clr    (clr),
    .cnt_en (cnt_en),
    .lim_new(lim_new),
    .cnt_q  (cnt_q),
    .lim_q  (lim_q),
    .hit    (hit)
  );

  dto_ctrl #(
    .RST_CYC(RST_CYC)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_ce     (sd_ce),
    .win_start (win_start),
    .data_done (data_done),
    .dreset_req(dreset_req),
    .hit       (hit),
    .clr_bit   (clr_bit),
    .load      (load),
    .clr       (clr),
    .cnt_en    (cnt_en),
    .st_q      (st_q),
    .flag_q    (dto_flag)
  );

  assign run_s       = (st_q == ST_RUN);
  assign dto_idle    = (st_q == ST_IDLE);
  assign dreset_busy = (st_q == ST_RST);

endmodule

// File: rtl/dto_chk.sv
module dto_chk #(
  parameter int CNT_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             rst_req,
  input logic             clr_req,
  input logic             flag,
  input logic             idle,
  input logic             busy,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim
);

  AST_FLAG_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(run)); // R2

  AST_CNT_BELOW_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < lim)); // R2

  AST_LIM_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones(lim) == 1)); // R3

  AST_DONE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done && !rst_req && !flag) |=> !flag); // R7

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && done && !rst_req) |=> idle); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R8

  AST_DRESET_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (busy && !idle)); // R10

  AST_DRESET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flag) |=> !flag); // R10

endmodule

bind sd_dto_timer dto_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .done   (data_done),
  .rst_req(dreset_req),
  .clr_req(clr_bit),
  .flag   (dto_flag),
  .idle   (dto_idle),
  .busy   (dreset_busy),
  .run    (run_s),
  .cnt    (cnt_q),
  .lim    (lim_q)
);

// File: tb/sim_sd_dto_timer.sv
module sim_sd_dto_timer;

  localparam int BS = 2;

  logic        clk;
  logic        rst_n;
  logic        sd_ce;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic        win_start;
  logic        data_done;
  logic        dreset_req;
  logic        w1c_we;
  logic [31:0] w1c_data;
  logic        dto_flag;
  logic        dto_idle;
  logic        dreset_busy;

  typedef struct {
    int    due;
    logic  fl;
    logic  id;
    logic  bz;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   fin = 0;

  sd_dto_timer #(.BASE_SHIFT(BS), .RST_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sd_ce(sd_ce), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .win_start(win_start), .data_done(data_done),
    .dreset_req(dreset_req), .w1c_we(w1c_we), .w1c_data(w1c_data),
    .dto_flag(dto_flag), .dto_idle(dto_idle), .dreset_busy(dreset_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int due, logic f, logic i, logic b, string tag);
    exp_t e;
    e.due = due; e.fl = f; e.id = i; e.bz = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_code(logic [3:0] code);
    ctl_we    = 1'b1;
    ctl_wdata = 32'(code) << 16;
    @(negedge clk);
    ctl_we    = 1'b0;
    ctl_wdata = 32'h0;
  endtask

  task automatic window(int len, string tag);
    int c;
    c = cyc;
    win_start = 1'b1;
    push(c + len, 1'b0, 1'b0, 1'b0, tag);
    push(c + len + 1, 1'b1, 1'b1, 1'b0, tag);
    @(negedge clk);
    win_start = 1'b0;
    repeat (len) @(negedge clk);
  endtask

  task automatic clear_flag(logic hitbit);
    w1c_we   = 1'b1;
    w1c_data = hitbit ? 32'h10 : ~32'h10;
    push(cyc + 1, !hitbit, 1'b1, 1'b0, "R8");
    @(negedge clk);
    w1c_we   = 1'b0;
    w1c_data = 32'h0;
  endtask

  // Monitor: pops each expected item on its due cycle and compares.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        e = q.pop_front();
        n_chk++;
        if (e.due != cyc || dto_flag !== e.fl || dto_idle !== e.id ||
            dreset_busy !== e.bz) begin
          n_bad++;
          $display("FAIL %s cyc=%0d: actual flag/idle/busy=%b%b%b expected=%b%b%b",
                   e.tag, cyc, dto_flag, dto_idle, dreset_busy, e.fl, e.id, e.bz);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; sd_ce = 1'b1; ctl_we = 1'b0; ctl_wdata = 32'h0;
    win_start = 1'b0; data_done = 1'b0; dreset_req = 1'b0;
    w1c_we = 1'b0; w1c_data = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then a window with the power-on exponent
    push(cyc + 1, 1'b0, 1'b1, 1'b0, "R1");
    @(negedge clk);
    window(1 << (14 + BS), "R1");
    clear_flag(1'b0);
    clear_flag(1'b1);
    // R3: code 15 clamps to 14
    set_code(4'd15);
    window(1 << (14 + BS), "R3");
    clear_flag(1'b1);
    // R2: two distinct codes
    set_code(4'd0);
    window(1 << BS, "R2");
    clear_flag(1'b1);
    set_code(4'd3);
    window(1 << (3 + BS), "R2");
    clear_flag(1'b1);
    // R4: exponent sampled at window start
    set_code(4'd0);
    c = cyc;
    win_start = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    ctl_we = 1'b1; ctl_wdata = 32'(3) << 16;
    push(c + 4, 1'b0, 1'b0, 1'b0, "R4");
    push(c + 5, 1'b1, 1'b1, 1'b0, "R4");
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = 32'h0;
    repeat (3) @(negedge clk);
    clear_flag(1'b1);
    window(32, "R4");
    clear_flag(1'b1);
    // R5: restart mid-window (code 3, 32 ticks)
    c = cyc;
    win_start = 1'b1;
    push(c + 21, 1'b0, 1'b0, 1'b0, "R5");
    @(negedge clk);
    win_start = 1'b0;
    repeat (19) @(negedge clk);
    win_start = 1'b1;
    push(c + 33, 1'b0, 1'b0, 1'b0, "R5");
    push(c + 52, 1'b0, 1'b0, 1'b0, "R5");
    push(c + 53, 1'b1, 1'b1, 1'b0, "R5");
    @(negedge clk);
    win_start = 1'b0;
    repeat (32) @(negedge clk);
    clear_flag(1'b1);
    // R6: ticks held off for 10 edges (code 0, 4 ticks)
    set_code(4'd0);
    c = cyc;
    win_start = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    sd_ce = 1'b0;
    push(c + 11, 1'b0, 1'b0, 1'b0, "R6");
    push(c + 14, 1'b0, 1'b0, 1'b0, "R6");
    push(c + 15, 1'b1, 1'b1, 1'b0, "R6");
    repeat (10) @(negedge clk);
    sd_ce = 1'b1;
    repeat (4) @(negedge clk);
    clear_flag(1'b1);
    // R7: done mid-window (code 3)
    set_code(4'd3);
    c = cyc;
    win_start = 1'b1;
    push(c + 11, 1'b0, 1'b1, 1'b0, "R7");
    push(c + 40, 1'b0, 1'b1, 1'b0, "R7");
    @(negedge clk);
    win_start = 1'b0;
    repeat (9) @(negedge clk);
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    repeat (29) @(negedge clk);
    // R7: done on the expiry edge (code 0)
    set_code(4'd0);
    c = cyc;
    win_start = 1'b1;
    push(c + 5, 1'b0, 1'b1, 1'b0, "R7");
    push(c + 8, 1'b0, 1'b1, 1'b0, "R7");
    @(negedge clk);
    win_start = 1'b0;
    repeat (3) @(negedge clk);
    data_done = 1'b1;
    @(negedge clk);
    data_done = 1'b0;
    repeat (3) @(negedge clk);
    // R9: clear on the expiry edge
    c = cyc;
    win_start = 1'b1;
    push(c + 5, 1'b1, 1'b1, 1'b0, "R9");
    @(negedge clk);
    win_start = 1'b0;
    repeat (3) @(negedge clk);
    w1c_we = 1'b1; w1c_data = 32'hFFFF_FFFF;
    @(negedge clk);
    w1c_we = 1'b0; w1c_data = 32'h0;
    // R10: data reset keeps a set flag, self-clears busy
    c = cyc;
    dreset_req = 1'b1;
    push(c + 1, 1'b1, 1'b0, 1'b1, "R10");
    push(c + 2, 1'b1, 1'b0, 1'b1, "R10");
    push(c + 3, 1'b1, 1'b1, 1'b0, "R10");
    @(negedge clk);
    dreset_req = 1'b0;
    repeat (2) @(negedge clk);
    clear_flag(1'b1);
    // R10: data reset aborts a window, start ignored while busy
    c = cyc;
    win_start = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    dreset_req = 1'b1;
    push(c + 2, 1'b0, 1'b0, 1'b1, "R10");
    push(c + 3, 1'b0, 1'b0, 1'b1, "R10");
    push(c + 4, 1'b0, 1'b1, 1'b0, "R10");
    push(c + 10, 1'b0, 1'b1, 1'b0, "R10");
    @(negedge clk);
    dreset_req = 1'b0;
    win_start = 1'b1;
    @(negedge clk);
    win_start = 1'b0;
    repeat (7) @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule